// File: doc/BRIEF.md
# Device Bus Transaction Master

This block runs one transaction on a shared serial device bus from the host side. A request carries a 4-bit slot, a 4-bit port, a 4-bit command, an optional write byte and a short-read flag. The controller pulls the device-bus select low and clocks out a 12-bit header. The slot nibble goes first and is consumed by an external slot decoder. The port and command nibbles follow and reach the addressed device. A put-byte command adds eight more data bits after the header.

After the last transmitted bit the controller waits for the device to drop its busy level on MISO. It then clocks in a response byte if the command produces one. The transaction ends with a one-cycle done pulse, and the received byte is held on the output until the next transaction completes. A busy-wait limit stops a transaction whose device never answers and reports an error.

The serial clock lines are shared with a memory engine. While the memory engine claims the lines and the controller is idle, the controller drives the memory select low. A new request is refused while that claim stands, so the two selects are never low at the same time.

Top module: `devbus_host`

## Requirements
- R1: Synchronous reset leaves both selects high, SCK and MOSI low, done low, the response byte 0x00 with the error flag clear, and the request ready (when no memory claim is present).
- R2: The header is sent MSB first as slot nibble, then port nibble, then command nibble. SCK idles low. MOSI changes only while SCK is low and is sampled by the device on the rising edge. Each SCK half period lasts cfg_half_div+1 clock cycles, so the first rising edge comes cfg_half_div+1 cycles after the accepting edge.
- R3: Command 0x3 appends the eight write-data bits, MSB first, after the command nibble, for 20 transmitted bits. Every other command sends exactly 12.
- R4: After the last transmitted bit no SCK edge is produced while MISO reads high. The wait ends at the first cycle MISO reads low.
- R5: A command whose bit 0 is 0 (0x0, 0x2, 0x4, ... 0xE) clocks in eight response bits, MSB first, each sampled at a falling SCK edge. A command whose bit 0 is 1 clocks in nothing and reports 0x00.
- R6: With the short-read flag set on a byte-returning command, only one response bit is clocked, select is released, and the reported byte is that bit copied into all eight positions. On a command that returns nothing, the flag has no effect.
- R7: If MISO stays high for cfg_busy_limit+1 consecutive cycles of the wait, the transaction aborts with select released, the response 0x00 and the error flag set. A wait that ends earlier leaves the error flag clear.
- R8: Done is high for exactly one cycle per transaction. The response byte and error flag change only in that cycle and hold their value otherwise.
- R9: The request is ready only while idle with mem_claim low. The memory select goes low one cycle after mem_claim is seen high in idle. The two selects are never low together.
- R10: The device-bus select goes low in the cycle after the request is accepted. It stays low through the transaction and is high in the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_half_div | input | DIV_W | SCK half period minus one, in clock cycles (at least 1) |
| cfg_busy_limit | input | TMO_W | Busy-wait cycles allowed before abort, minus one |
| mem_claim | input | 1 | Memory engine requests the shared serial lines |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_slot | input | 4 | Slot number, first header nibble |
| req_port | input | 4 | Port number, second header nibble |
| req_cmd | input | 4 | Command, third header nibble |
| req_wdata | input | 8 | Data byte sent after the header for command 0x3 |
| req_short | input | 1 | End the read after the first response bit |
| done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 8 | Received byte, held until the next completion |
| rsp_err | output | 1 | Busy-wait abort flag, held with rsp_data |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data and busy level from the device |
| bus_sel_n | output | 1 | Device-bus select, active low |
| mem_sel_n | output | 1 | Memory select, active low |

## Verification
The accepting edge is the reference point for most results. The bench drives a request at a falling clock edge and samples the select one falling edge later. It then counts falling edges until SCK reads high, and that count must equal cfg_half_div+1. Done is due in the cycle that follows the last falling SCK edge, or the last busy cycle of the wait. The bench samples done, the response byte, the error flag and the select together in that cycle, and expects done low one cycle later. The memory select must follow mem_claim after one cycle, so the bench checks it two falling edges after changing the claim. A bus-side device model records the header bits, the SCK rises and any rises seen while it holds MISO busy. Each value is compared with what the request arithmetic predicts.

// File: rtl/devbus_pkg.sv
package devbus_pkg;
  localparam int SLOT_W     = 4;
  localparam int PORT_W     = 4;
  localparam int CMD_W      = 4;
  localparam int BYTE_W     = 8;
  localparam int HDR_BITS   = SLOT_W + PORT_W + CMD_W;
  localparam int FRAME_BITS = HDR_BITS + BYTE_W;
  localparam int BITCNT_W   = $clog2(FRAME_BITS);

  localparam logic [CMD_W-1:0] CMD_PUT_BYTE = 4'h3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_RECV
  } seq_state_e;

  // Commands with bit 0 clear produce one response byte.
  function automatic logic cmd_answers(input logic [CMD_W-1:0] c);
    return ~c[0];
  endfunction
endpackage

// File: rtl/devbus_half_tick.sv
module devbus_half_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_comb tick = run && (cnt_q == half_div);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/devbus_busy_timer.sv
module devbus_busy_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             busy,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] cnt_q;

  always_comb expired = arm && busy && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst || !arm)          cnt_q <= '0;
    else if (busy && !expired) cnt_q <= cnt_q + 1'b1;
  end

  // R7: the count never passes the limit while waiting
  a_r7_count_bounded: assert property (@(posedge clk) disable iff (rst)
    (arm && $stable(limit) && $past(arm)) |-> (cnt_q <= limit));
endmodule

// File: rtl/devbus_seq.sv
module devbus_seq
  import devbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_claim,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic [PORT_W-1:0] req_port,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic [BYTE_W-1:0] req_wdata,
  input  logic              req_short,
  input  logic              tick,
  input  logic              expired,
  output logic              run,
  output logic              arm,
  output logic              busy,
  input  logic              spi_miso,
  output logic              spi_sck,
  output logic              spi_mosi,
  output logic              bus_sel_n,
  output logic              mem_sel_n,
  output logic              done,
  output logic [BYTE_W-1:0] rsp_data,
  output logic              rsp_err
);
  seq_state_e              state_q;
  logic [FRAME_BITS-1:0]   frame_q;
  logic [BITCNT_W-1:0]     bit_q;
  logic [CMD_W-1:0]        cmd_q;
  logic                    short_q;
  logic [BYTE_W-2:0]       rx_q;
  logic                    miso_q;
  logic                    accept;
  logic [BITCNT_W-1:0]     last_tx;

  always_comb begin
    req_ready = (state_q == ST_IDLE) && !mem_claim;
    accept    = req_valid && req_ready;
    run       = (state_q == ST_SEND) || (state_q == ST_RECV);
    arm       = (state_q == ST_WAIT);
    busy      = miso_q;
    last_tx   = (cmd_q == CMD_PUT_BYTE) ? BITCNT_W'(FRAME_BITS - 1)
                                        : BITCNT_W'(HDR_BITS - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      frame_q   <= '0;
      bit_q     <= '0;
      cmd_q     <= '0;
      short_q   <= 1'b0;
      rx_q      <= '0;
      miso_q    <= 1'b0;
      spi_sck   <= 1'b0;
      spi_mosi  <= 1'b0;
      bus_sel_n <= 1'b1;
      mem_sel_n <= 1'b1;
      done      <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
    end else begin
      done      <= 1'b0;
      miso_q    <= spi_miso;
      mem_sel_n <= !(mem_claim && (state_q == ST_IDLE));
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            frame_q   <= {req_slot, req_port, req_cmd, req_wdata};
            cmd_q     <= req_cmd;
            short_q   <= req_short;
            bit_q     <= '0;
            bus_sel_n <= 1'b0;
            spi_mosi  <= req_slot[SLOT_W-1];
            spi_sck   <= 1'b0;
            state_q   <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (tick) begin
            if (!spi_sck) begin
              spi_sck <= 1'b1;
            end else begin
              spi_sck <= 1'b0;
              if (bit_q == last_tx) begin
                spi_mosi <= 1'b0;
                state_q  <= ST_WAIT;
              end else begin
                bit_q    <= bit_q + 1'b1;
                frame_q  <= frame_q << 1;
                spi_mosi <= frame_q[FRAME_BITS-2];
              end
            end
          end
        end
        ST_WAIT: begin
          if (!miso_q) begin
            if (cmd_answers(cmd_q)) begin
              bit_q   <= '0;
              state_q <= ST_RECV;
            end else begin
              bus_sel_n <= 1'b1;
              done      <= 1'b1;
              rsp_data  <= '0;
              rsp_err   <= 1'b0;
              state_q   <= ST_IDLE;
            end
          end else if (expired) begin
            bus_sel_n <= 1'b1;
            done      <= 1'b1;
            rsp_data  <= '0;
            rsp_err   <= 1'b1;
            state_q   <= ST_IDLE;
          end
        end
        ST_RECV: begin
          if (tick) begin
            if (!spi_sck) begin
              spi_sck <= 1'b1;
            end else begin
              spi_sck <= 1'b0;
              rx_q    <= {rx_q[BYTE_W-3:0], miso_q};
              if (short_q || (bit_q == BITCNT_W'(BYTE_W - 1))) begin
                bus_sel_n <= 1'b1;
                done      <= 1'b1;
                rsp_data  <= short_q ? {BYTE_W{miso_q}} : {rx_q, miso_q};
                rsp_err   <= 1'b0;
                state_q   <= ST_IDLE;
              end else begin
                bit_q <= bit_q + 1'b1;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9: memory and device selects are mutually exclusive
  a_r9_one_select_low: assert property (@(posedge clk) disable iff (rst)
    !(!bus_sel_n && !mem_sel_n));

  // R8: completion pulse lasts one cycle
  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: results only move with done
  a_r8_rsp_held: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(rsp_data) && $stable(rsp_err)));

  // R2: no serial clock while deselected
  a_r2_sck_low_when_idle: assert property (@(posedge clk) disable iff (rst)
    bus_sel_n |-> !spi_sck);

  // R4: no clocking while the device signals busy
  a_r4_quiet_while_busy: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT) |-> !spi_sck);

  // R5: receive phase only for byte-returning commands
  a_r5_recv_only_answering: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RECV) |-> cmd_answers(cmd_q));

  // R7: busy-wait expiry ends the transaction with the error flag
  a_r7_abort_flags_error: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_WAIT) && busy && expired) |=> (done && rsp_err && bus_sel_n));

  // R10: select drops right after acceptance
  a_r10_select_from_accept: assert property (@(posedge clk) disable iff (rst)
    accept |=> !bus_sel_n);
endmodule

// File: rtl/devbus_host.sv
module devbus_host
  import devbus_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] cfg_half_div,
  input  logic [TMO_W-1:0] cfg_busy_limit,
  input  logic             mem_claim,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [3:0]       req_slot,
  input  logic [3:0]       req_port,
  input  logic [3:0]       req_cmd,
  input  logic [7:0]       req_wdata,
  input  logic             req_short,
  output logic             done,
  output logic [7:0]       rsp_data,
  output logic             rsp_err,
  output logic             spi_sck,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic             bus_sel_n,
  output logic             mem_sel_n
);
  logic tick, expired, run, arm, busy;

  devbus_half_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .run(run), .half_div(cfg_half_div), .tick(tick)
  );

  devbus_busy_timer #(.TMO_W(TMO_W)) u_timer (
    .clk(clk), .rst(rst), .arm(arm), .busy(busy), .limit(cfg_busy_limit),
    .expired(expired)
  );

  devbus_seq u_seq (
    .clk(clk), .rst(rst), .mem_claim(mem_claim),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_slot(req_slot), .req_port(req_port), .req_cmd(req_cmd),
    .req_wdata(req_wdata), .req_short(req_short),
    .tick(tick), .expired(expired), .run(run), .arm(arm), .busy(busy),
    .spi_miso(spi_miso), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .bus_sel_n(bus_sel_n), .mem_sel_n(mem_sel_n),
    .done(done), .rsp_data(rsp_data), .rsp_err(rsp_err)
  );
endmodule

// File: tb/devbus_host_bench.sv
`timescale 1ns/1ps
module devbus_host_bench;
  localparam int DIV_W = 8;
  localparam int TMO_W = 16;

  logic             clk = 1'b0;
  logic             rst;
  logic [DIV_W-1:0] cfg_half_div;
  logic [TMO_W-1:0] cfg_busy_limit;
  logic             mem_claim;
  logic             req_valid;
  logic             req_ready;
  logic [3:0]       req_slot, req_port, req_cmd;
  logic [7:0]       req_wdata;
  logic             req_short;
  logic             done;
  logic [7:0]       rsp_data;
  logic             rsp_err;
  logic             spi_sck, spi_mosi, spi_miso;
  logic             bus_sel_n, mem_sel_n;

  int n_chk = 0;
  int n_bad = 0;
  int rise_cnt = 0;
  int overlap_cnt = 0;

  int          dev_ntx = 12;
  logic [7:0]  dev_rsp = 8'h00;
  bit          dev_rsp_en = 1'b0;
  int          dev_busy = 0;
  bit          dev_hang = 1'b0;
  logic [19:0] dev_hdr;
  int          dev_busy_rises;

  always #2.5 clk = ~clk;

  devbus_host #(.DIV_W(DIV_W), .TMO_W(TMO_W)) u_devbus_host (
    .clk(clk), .rst(rst), .cfg_half_div(cfg_half_div),
    .cfg_busy_limit(cfg_busy_limit), .mem_claim(mem_claim),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_slot(req_slot), .req_port(req_port), .req_cmd(req_cmd),
    .req_wdata(req_wdata), .req_short(req_short),
    .done(done), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .bus_sel_n(bus_sel_n), .mem_sel_n(mem_sel_n)
  );

  always @(posedge spi_sck) if (!bus_sel_n) rise_cnt <= rise_cnt + 1;
  always @(negedge clk) if (!rst && !bus_sel_n && !mem_sel_n) overlap_cnt <= overlap_cnt + 1;

  // Device model: captures bits on rising SCK, holds busy, returns a byte
  initial begin
    spi_miso = 1'b0;
    forever begin
      int base;
      @(negedge bus_sel_n);
      dev_hdr = '0;
      for (int k = 0; k < dev_ntx; k++) begin
        @(posedge spi_sck);
        dev_hdr = {dev_hdr[18:0], spi_mosi};
        if (k == 3) spi_miso = 1'b1;
      end
      @(negedge spi_sck);
      base = rise_cnt;
      if (!dev_hang) begin
        repeat (dev_busy) @(negedge clk);
        dev_busy_rises = rise_cnt - base;
        spi_miso = 1'b0;
        if (dev_rsp_en) begin
          for (int k = 7; k >= 0; k--) begin
            @(posedge spi_sck or posedge bus_sel_n);
            if (bus_sel_n) break;
            spi_miso = dev_rsp[k];
          end
        end
      end
      wait (bus_sel_n);
      spi_miso = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic txn(input logic [3:0] s, input logic [3:0] p, input logic [3:0] c,
                     input logic [7:0] w, input bit shrt, input logic [7:0] rb,
                     input int busy, input bit hang);
    int ntx, base, n, exp_rises;
    logic [7:0] exp_rsp;
    logic [19:0] exp_hdr;
    bit ans, exp_err;
    ntx = (c == 4'h3) ? 20 : 12;
    ans = !c[0];
    exp_hdr = (ntx == 20) ? {s, p, c, w} : {8'h00, s, p, c};
    exp_err = hang;
    if (hang || !ans) begin exp_rsp = 8'h00; exp_rises = ntx; end
    else if (shrt)    begin exp_rsp = {8{rb[7]}}; exp_rises = ntx + 1; end
    else              begin exp_rsp = rb; exp_rises = ntx + 8; end
    dev_ntx = ntx; dev_rsp = rb; dev_rsp_en = ans; dev_busy = busy;
    dev_hang = hang; dev_busy_rises = -1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_slot = s; req_port = p; req_cmd = c;
    req_wdata = w; req_short = shrt;
    base = rise_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!bus_sel_n, "R10 select low after accept", bus_sel_n, 0);
    n = 0;
    while (!spi_sck && n < 1000) begin @(negedge clk); n++; end
    chk(n == int'(cfg_half_div) + 1, "R2 first rise latency", n, int'(cfg_half_div) + 1);
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk(done, "R8 done seen", done, 1);
    chk(rsp_data == exp_rsp, "R5/R6 response byte", rsp_data, exp_rsp);
    chk(rsp_err == exp_err, "R7 error flag", rsp_err, exp_err);
    chk(dev_hdr == exp_hdr, "R2/R3 header bits", dev_hdr, exp_hdr);
    chk(rise_cnt - base == exp_rises, "R3/R5 SCK rise count", rise_cnt - base, exp_rises);
    chk(bus_sel_n, "R10 select high at done", bus_sel_n, 1);
    if (!hang && busy > 0)
      chk(dev_busy_rises == 0, "R4 no SCK while busy", dev_busy_rises, 0);
    @(negedge clk);
    chk(!done, "R8 done single cycle", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] held;
    bit held_err;
    rst = 1'b1; cfg_half_div = 8'd1; cfg_busy_limit = 16'd200; mem_claim = 1'b0;
    req_valid = 1'b0; req_slot = '0; req_port = '0; req_cmd = '0;
    req_wdata = '0; req_short = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(bus_sel_n && mem_sel_n, "R1 selects high", {bus_sel_n, mem_sel_n}, 3);
    chk(!spi_sck && !spi_mosi, "R1 SCK/MOSI low", {spi_sck, spi_mosi}, 0);
    chk(!done && rsp_data == 8'h00 && !rsp_err, "R1 outputs clear", rsp_data, 0);
    chk(req_ready, "R1 ready", req_ready, 1);

    // Sweep all commands with several slot/port/data/busy patterns
    for (int c = 0; c < 16; c++)
      for (int v = 0; v < 4; v++)
        txn(4'(c + v * 3), 4'(15 - c + v), 4'(c), 8'(c * 17 + v * 29 + 1),
            1'b0, 8'(c * 37 + v * 11 + 5), v * 3, 1'b0);

    // R6 short reads
    txn(4'h2, 4'h1, 4'h0, 8'h00, 1'b1, 8'h80, 2, 1'b0);
    txn(4'h9, 4'h3, 4'h4, 8'h00, 1'b1, 8'h7F, 0, 1'b0);
    txn(4'hA, 4'h6, 4'h5, 8'h00, 1'b1, 8'hFF, 1, 1'b0);

    // R7 busy-wait limit
    cfg_busy_limit = 16'd20;
    txn(4'h5, 4'h5, 4'h2, 8'h00, 1'b0, 8'hC3, 0, 1'b1);
    txn(4'h5, 4'h5, 4'h2, 8'h00, 1'b0, 8'h3C, 12, 1'b0);
    txn(4'h1, 4'h2, 4'h7, 8'h00, 1'b0, 8'h00, 0, 1'b1);
    cfg_busy_limit = 16'd200;

    // R2 slower serial clock
    cfg_half_div = 8'd3;
    txn(4'hC, 4'h0, 4'h3, 8'hA5, 1'b0, 8'h00, 4, 1'b0);
    txn(4'h3, 4'hE, 4'h6, 8'h00, 1'b0, 8'h5A, 1, 1'b0);
    cfg_half_div = 8'd1;

    // R8 result held while idle
    held = rsp_data; held_err = rsp_err;
    repeat (10) @(negedge clk);
    chk(rsp_data == held && rsp_err == held_err, "R8 result held", rsp_data, held);

    // R9 memory claim
    mem_claim = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(!mem_sel_n, "R9 memory select low", mem_sel_n, 0);
    chk(!req_ready, "R9 not ready under claim", req_ready, 0);
    req_valid = 1'b1; req_cmd = 4'h1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(bus_sel_n, "R9 request refused under claim", bus_sel_n, 1);
    end
    req_valid = 1'b0;
    mem_claim = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(mem_sel_n && req_ready, "R9 claim released", {mem_sel_n, req_ready}, 3);
    txn(4'h7, 4'h7, 4'h6, 8'h00, 1'b0, 8'h96, 2, 1'b0);
    chk(overlap_cnt == 0, "R9 selects never both low", overlap_cnt, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule